// File: doc/BRIEF.md
# Multi-cycle 8/16-bit multiply unit

This block is the multiply engine for a small 16-bit execution core. It runs four operations: a signed 8x8 multiply of the operands' low bytes, an unsigned 8x8 multiply of the same bytes, a signed 16x16 fractional multiply that keeps the upper half of the 32-bit product, and a signed 16x16 long multiply that keeps the upper half and also hands out the lower half for a second register write. Register file access and instruction decode are outside the block. The caller supplies two 16-bit operands. For the 16x16 forms, the second operand is the value of the fixed coefficient register, register 6.

A pulse on `start` while the unit is idle captures the opcode, both operands and the speed bit. The unit then counts out its latency and raises `done` for one cycle. Latency depends on operand size and on the speed bit. When the speed bit is clear, the 8x8 forms take two extra cycles and the 16x16 forms take four. When it is set, the 8x8 forms take none and the 16x16 forms take eight. The controller has three states. `ST_IDLE` waits for `start`. It goes to `ST_WAIT` when extra cycles are due, or straight to `ST_DONE` when none are. `ST_WAIT` counts down and moves to `ST_DONE` on its last count. `ST_DONE` pulses `done` and returns to `ST_IDLE`.

Top module: `mulx_unit`

## Requirements
- R1: After reset, `busy`, `done`, `carry_we` and `low_we` are 0.
- R2: Opcode 2'b00 multiplies bits [7:0] of both operands as two's complement numbers and returns the 16-bit product on `result`. Bits [15:8] of the operands have no effect.
- R3: Opcode 2'b01 multiplies bits [7:0] of both operands as unsigned numbers and returns the 16-bit product on `result`.
- R4: For opcodes 2'b00 and 2'b01, `flag_sign` is product bit 15 and `flag_zero` is set when the product is zero. `carry_we` stays 0, so carry is not updated.
- R5: Opcode 2'b10 forms the signed 32-bit product of both full operands and returns bits [31:16] on `result`. `flag_sign` is bit 15 of that half, and `flag_zero` is set when that half is zero.
- R6: For opcodes 2'b10 and 2'b11, `carry_we` is 1 in the `done` cycle and `flag_carry` equals bit 15 of the 32-bit product.
- R7: Opcode 2'b11 behaves like 2'b10. In addition, `low_we` is 1 in the `done` cycle and `low_word` carries product bits [15:0]. `low_we` is 0 for every other opcode and outside `done`.
- R8: For the 8x8 opcodes, `done` is high in cycle 1+X after the clock edge that accepts `start`. X is 2 when `fast` was 0 at that edge and 0 when it was 1.
- R9: For the 16x16 opcodes, `done` is high in cycle 1+X after the accepting edge. X is 4 when `fast` was 0 and 8 when it was 1.
- R10: `busy` is high from the cycle after the accepting edge through the `done` cycle. `done` lasts exactly one cycle, and `busy` is 0 in the cycle after it.
- R11: `start` is ignored while `busy` is high. The operation in flight completes with its own operands, and no extra `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a multiply (sampled while idle) |
| op | input | 2 | Opcode: 00 signed 8x8, 01 unsigned 8x8, 10 fractional 16x16, 11 long 16x16 |
| fast | input | 1 | Speed-mode bit, sampled with start |
| opnd_a | input | 16 | Source operand |
| opnd_b | input | 16 | Second operand (register 6 value for 16x16 forms) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Destination value, valid with done |
| flag_sign | output | 1 | Sign flag, valid with done |
| flag_zero | output | 1 | Zero flag, valid with done |
| flag_carry | output | 1 | Carry flag, meaningful when carry_we |
| carry_we | output | 1 | Carry flag update strobe (16x16 forms) |
| low_we | output | 1 | Low-word write strobe (long form) |
| low_word | output | 16 | Lower 16 bits of the 32-bit product |

## Verification
The 8x8 opcodes are driven with high bytes set to junk, with mixed-sign and equal-sign low bytes including -128 squared, and with a zero low byte. These separate signed from unsigned treatment and show that the upper byte is masked. The 16x16 opcodes are given products whose bit 15 is set while the upper half is zero, products of -1 by -1, and products of a negative extreme by one. These show that carry comes from the discarded half and that zero tests only the upper half. Each opcode is run with both speed settings, so that the narrow and wide latencies move in opposite directions. A start issued mid-operation checks that operands are held.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

    typedef enum logic [1:0] {
        MOP_SMUL8  = 2'b00,
        MOP_UMUL8  = 2'b01,
        MOP_FRAC16 = 2'b10,
        MOP_LONG16 = 2'b11
    } mop_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } mst_e;

    function automatic logic op_is_wide(input mop_e o);
        return o[1];
    endfunction

endpackage

// File: rtl/mulx_datapath.sv
module mulx_datapath
    import mulx_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  mop_e             op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] res,
    output logic [WIDTH-1:0] low,
    output logic             sgn,
    output logic             zro,
    output logic             cry
);
    localparam int HALF = WIDTH / 2;
    localparam int DBL  = 2 * WIDTH;

    logic [WIDTH-1:0] na_ext, nb_ext, narrow_prod;
    logic [DBL-1:0]   wa_ext, wb_ext, wide_prod;

    always_comb begin
        if (op == MOP_SMUL8) begin
            na_ext = {{HALF{opa[HALF-1]}}, opa[HALF-1:0]};
            nb_ext = {{HALF{opb[HALF-1]}}, opb[HALF-1:0]};
        end else begin
            na_ext = {{HALF{1'b0}}, opa[HALF-1:0]};
            nb_ext = {{HALF{1'b0}}, opb[HALF-1:0]};
        end
        narrow_prod = na_ext * nb_ext;
        wa_ext      = {{WIDTH{opa[WIDTH-1]}}, opa};
        wb_ext      = {{WIDTH{opb[WIDTH-1]}}, opb};
        wide_prod   = wa_ext * wb_ext;
    end

    always_comb begin
        if (op_is_wide(op)) begin
            res = wide_prod[DBL-1:WIDTH];
            cry = wide_prod[WIDTH-1];
        end else begin
            res = narrow_prod;
            cry = 1'b0;
        end
        low = wide_prod[WIDTH-1:0];
        sgn = res[WIDTH-1];
        zro = (res == '0);
    end

    // R2: equal-sign signed bytes can never give a negative product
    always_comb begin
        if (op == MOP_SMUL8 && opa[HALF-1] == opb[HALF-1])
            assert_sign_pos_R2: assert (narrow_prod[WIDTH-1] == 1'b0);
    end

endmodule

// File: rtl/mulx_ctrl.sv
module mulx_ctrl
    import mulx_pkg::*;
#(
    parameter int NARROW_SLOW_EXTRA = 2,
    parameter int WIDE_BASE_EXTRA   = 4,
    parameter int WIDE_FAST_ADD     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic wide,
    input  logic fast,
    output logic accept,
    output logic busy,
    output logic done
);
    localparam int WIDE_MAX  = WIDE_BASE_EXTRA + WIDE_FAST_ADD;
    localparam int MAX_EXTRA = (WIDE_MAX > NARROW_SLOW_EXTRA) ? WIDE_MAX : NARROW_SLOW_EXTRA;
    localparam int CW        = $clog2(MAX_EXTRA + 1) + 1;

    mst_e          state, state_nx;
    logic [CW-1:0] cnt, extra_sel;

    always_comb begin
        if (wide)
            extra_sel = fast ? CW'(WIDE_MAX) : CW'(WIDE_BASE_EXTRA);
        else
            extra_sel = fast ? '0 : CW'(NARROW_SLOW_EXTRA);
    end

    assign accept = (state == ST_IDLE) && start;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = (extra_sel == '0) ? ST_DONE : ST_WAIT;
            ST_WAIT: if (cnt == CW'(1)) state_nx = ST_DONE;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (accept)
                cnt <= extra_sel;
            else if (state == ST_WAIT)
                cnt <= cnt - CW'(1);
        end
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_WAIT: busy = 1'b1;
            ST_DONE: begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    // latency checker: busy cycles counted before done must match the selected extra
    logic [CW-1:0] lat_q, busy_len;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q    <= '0;
            busy_len <= '0;
        end else begin
            if (accept) lat_q <= extra_sel;
            busy_len <= busy ? busy_len + CW'(1) : '0;
        end
    end

    assert_latency_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_len == lat_q));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit
    import mulx_pkg::*;
#(
    parameter int WIDTH             = 16,
    parameter int NARROW_SLOW_EXTRA = 2,
    parameter int WIDE_BASE_EXTRA   = 4,
    parameter int WIDE_FAST_ADD     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic             fast,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result,
    output logic             flag_sign,
    output logic             flag_zero,
    output logic             flag_carry,
    output logic             carry_we,
    output logic             low_we,
    output logic [WIDTH-1:0] low_word
);
    mop_e             op_q;
    logic [WIDTH-1:0] a_q, b_q;
    logic             accept;

    mulx_ctrl #(
        .NARROW_SLOW_EXTRA(NARROW_SLOW_EXTRA),
        .WIDE_BASE_EXTRA  (WIDE_BASE_EXTRA),
        .WIDE_FAST_ADD    (WIDE_FAST_ADD)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .wide  (op[1]),
        .fast  (fast),
        .accept(accept),
        .busy  (busy),
        .done  (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= MOP_SMUL8;
            a_q  <= '0;
            b_q  <= '0;
        end else if (accept) begin
            op_q <= mop_e'(op);
            a_q  <= opnd_a;
            b_q  <= opnd_b;
        end
    end

    mulx_datapath #(.WIDTH(WIDTH)) u_dp (
        .op (op_q),
        .opa(a_q),
        .opb(b_q),
        .res(result),
        .low(low_word),
        .sgn(flag_sign),
        .zro(flag_zero),
        .cry(flag_carry)
    );

    assign carry_we = done && op_is_wide(op_q);
    assign low_we   = done && (op_q == MOP_LONG16);

    assert_hold_operands_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_q) && $stable(b_q) && $stable(op_q)));

    assert_low_we_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        low_we |-> (done && carry_we));

    assert_no_carry_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !op_is_wide(op_q)) |-> !carry_we);

endmodule

// File: tb/sim_mulx_unit.sv
module sim_mulx_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'b00;
    logic        fast = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic        busy, done, flag_sign, flag_zero, flag_carry, carry_we, low_we;
    logic [15:0] result, low_word;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mulx_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .fast(fast),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .busy(busy), .done(done),
        .result(result), .flag_sign(flag_sign), .flag_zero(flag_zero),
        .flag_carry(flag_carry), .carry_we(carry_we), .low_we(low_we),
        .low_word(low_word)
    );

    // {op, fast, a, b, result, low, sign, zero, carry, extra}
    localparam int NV = 10;
    localparam logic [73:0] VEC [NV] = '{
        {2'b00, 1'b1, 16'h12FD, 16'hAB04, 16'hFFF4, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0},
        {2'b00, 1'b0, 16'h0080, 16'h0080, 16'h4000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd2},
        {2'b01, 1'b1, 16'h00FF, 16'h00FF, 16'hFE01, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0},
        {2'b01, 1'b0, 16'hFF00, 16'h1234, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 4'd2},
        {2'b10, 1'b0, 16'h4000, 16'h4000, 16'h1000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd4},
        {2'b10, 1'b1, 16'h8000, 16'h0001, 16'hFFFF, 16'h8000, 1'b1, 1'b0, 1'b1, 4'd8},
        {2'b11, 1'b0, 16'h1234, 16'h0100, 16'h0012, 16'h3400, 1'b0, 1'b0, 1'b0, 4'd4},
        {2'b11, 1'b1, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 1'b0, 1'b1, 1'b0, 4'd8},
        {2'b10, 1'b0, 16'h0003, 16'h5555, 16'h0000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 4'd4},
        {2'b11, 1'b0, 16'h7FFF, 16'h7FFF, 16'h3FFF, 16'h0001, 1'b0, 1'b0, 1'b0, 4'd4}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // issue one operation and wait for done; returns cycles counted to done
    task automatic issue(input logic [1:0] o, input logic f, input logic [15:0] a,
                         input logic [15:0] b, output int cyc);
        @(negedge clk);
        op = o; fast = f; opnd_a = a; opnd_b = b; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0; opnd_a = 16'hDEAD; opnd_b = 16'hBEEF; op = ~o; fast = ~f;
        cyc = 1;
        while (!done && cyc < 40) begin
            chk("R10 busy while pending", {31'd0, busy}, 32'd1);
            @(negedge clk);
            cyc++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 strobes", {30'd0, carry_we, low_we}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            v = VEC[i];
            issue(v[73:72], v[71], v[70:55], v[54:39], cyc);
            chk(v[73] ? "R9 latency" : "R8 latency", cyc, 32'(v[3:0]) + 1);
            chk(v[73] ? "R5 result" : (v[72] ? "R3 result" : "R2 result"), {16'd0, result}, {16'd0, v[38:23]});
            chk(v[73] ? "R5 sign" : "R4 sign", {31'd0, flag_sign}, {31'd0, v[6]});
            chk(v[73] ? "R5 zero" : "R4 zero", {31'd0, flag_zero}, {31'd0, v[5]});
            chk(v[73] ? "R6 carry_we" : "R4 carry_we", {31'd0, carry_we}, {31'd0, v[73]});
            if (v[73]) chk("R6 carry", {31'd0, flag_carry}, {31'd0, v[4]});
            chk("R7 low_we", {31'd0, low_we}, {31'd0, v[73] & v[72]});
            if (v[73] && v[72]) chk("R7 low_word", {16'd0, low_word}, {16'd0, v[22:7]});
            @(negedge clk);
            chk("R10 done single", {30'd0, done, busy}, 32'd0);
            chk("R7 low_we idle", {31'd0, low_we}, 32'd0);
        end

        // R11: start while busy is ignored
        @(negedge clk);
        op = 2'b10; fast = 1'b0; opnd_a = 16'h4000; opnd_b = 16'h4000; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op = 2'b00; opnd_a = 16'h0002; opnd_b = 16'h0003; fast = 1'b1;
        cyc = 1;
        while (!done && cyc < 40) begin
            if (cyc == 3) start = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk("R11 latency kept", cyc, 32'd5);
        chk("R11 result kept", {16'd0, result}, 32'h1000);
        chk("R11 carry_we kept", {31'd0, carry_we}, 32'd1);
        begin
            int extra_done = 0;
            for (int k = 0; k < 15; k++) begin
                @(negedge clk);
                if (done) extra_done++;
            end
            chk("R11 no extra done", extra_done, 32'd0);
        end

        // R2: high bytes have no effect on signed narrow product
        issue(2'b00, 1'b0, 16'h7F05, 16'h80FF, cyc);
        chk("R2 high bytes masked", {16'd0, result}, 32'h0000FFFB);
        chk("R8 slow narrow", cyc, 32'd3);

        // reset mid-operation returns to idle
        @(negedge clk);
        op = 2'b11; fast = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-op", {30'd0, busy, done}, 32'd0);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule